// File: doc/BRIEF.md
# Flash Global Erase Sequencer

This block is a host-side controller that runs a whole-device flash erase on a target reached over a byte-serial in-circuit programming link. It sits on top of a byte shifter. The shifter moves one byte per request, reports `shf_busy` while it is working, and returns one response byte with `rx_valid` when the request was a read command. The serial bit protocol and the target side are outside this block.

A one-cycle `start` pulse runs a fixed sequence. First the block sends the control-register write command and then the erase-all opcode. It then waits a settling time of `WAIT_US` microseconds, counted in clock cycles of `CLK_HZ`. Next it issues `N_DUMMY` throw-away data reads with auto-increment. Only after those reads does it poll the control-register read command until the status byte shows the erase has finished or shows a fault. The settling wait and the dummy reads are mandatory, because the target never clears its busy flag if polling starts straight away. The outcome is reported as a one-cycle `done` or `error` pulse, and `err_code` gives the cause of an error. All four command and opcode byte values are parameters.

Top module: `gerase_seq`

## Requirements
- R1: While reset is held, and until `start` is seen, `tx_valid`, `done` and `error` are 0.
- R2: The first two bytes launched after `start` are `CMD_WR_CTRL` and then `OP_ERASE_ALL`, in that order.
- R3: The next command after the opcode is launched no earlier than WAIT_CYC = (CLK_HZ/1000)*WAIT_US/1000 cycles after the opcode launch, and no later than 4 cycles after that.
- R4: After the wait, exactly `N_DUMMY` `CMD_RD_INC` commands are sent, one per response. The bytes they return are discarded and do not affect the outcome, even when they have the busy bit or error bits set.
- R5: After the dummy reads, `CMD_RD_CTRL` is sent again after each status response whose bit 7 (busy) is 1 and whose error bits (`rx_byte & ERR_MASK`, default mask 8'h7F) are all 0.
- R6: A status response with bit 7 = 0 and no error bits raises `done` one cycle after its `rx_valid`, with `err_code` = 2'b00.
- R7: A status response with any error bit set raises `error` one cycle after its `rx_valid`, with `err_code` = 2'b01. This holds even if bit 7 is also set, and polling stops.
- R8: If `POLL_LIMIT` status responses in a row all show busy and no error, `error` is raised with `err_code` = 2'b10 one cycle after the last of them, after exactly `POLL_LIMIT` polls.
- R9: `done` and `error` are one-cycle pulses, are never high together, and are produced once per sequence. The block then returns to idle and accepts a new `start`.
- R10: A `start` pulse while a sequence is running is ignored. No extra command is sent and no extra result is produced.
- R11: A byte is launched only when `shf_busy` was low at the launching edge. `tx_valid` is never high on two consecutive cycles. A read step advances only on `rx_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an erase sequence (pulse) |
| shf_busy | input | 1 | Byte shifter is working and cannot accept a byte |
| rx_valid | input | 1 | Response byte from the shifter is valid this cycle |
| rx_byte | input | 8 | Response byte from the shifter |
| tx_valid | output | 1 | Launch request for `tx_byte` (one cycle) |
| tx_byte | output | 8 | Command or opcode byte to shift out |
| done | output | 1 | Erase finished without fault (one-cycle pulse) |
| error | output | 1 | Erase failed or timed out (one-cycle pulse) |
| err_code | output | 2 | Cause of an error: 01 status fault, 10 poll timeout |

## Verification
The result pulse is due exactly one cycle after the `rx_valid` of the deciding status byte. The bench stamps both events with a cycle counter and requires a difference of one. The first dummy read must launch between WAIT_CYC and WAIT_CYC+4 cycles after the opcode launch, and the bench measures this gap with the same stamps. All stamps are taken at the falling edge, so every registered output has settled and every shifter-model input is stable before the next rising edge.

// File: rtl/gerase_pkg.sv
package gerase_pkg;
   typedef enum logic [2:0] {
      ST_IDLE, ST_CMD, ST_OP, ST_WAIT, ST_DRD, ST_DRX, ST_POLL, ST_PRX
   } gerase_state_t;

   typedef enum logic [1:0] {
      EC_NONE    = 2'b00,
      EC_STATUS  = 2'b01,
      EC_TIMEOUT = 2'b10
   } gerase_err_t;
endpackage

// File: rtl/gerase_timer.sv
module gerase_timer #(
   parameter int CYCLES = 500000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   output logic zero
);
   localparam int TW = (CYCLES > 1) ? $clog2(CYCLES + 1) : 1;
   logic [TW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)          cnt <= '0;
      else if (load)       cnt <= TW'(CYCLES - 1);
      else if (cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign zero = (cnt == '0);
endmodule

// File: rtl/gerase_ctr.sv
module gerase_ctr #(
   parameter int LIMIT = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic inc,
   output logic last
);
   localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n || clr) cnt <= '0;
      else if (inc)      cnt <= cnt + 1'b1;
   end

   assign last = (cnt == CW'(LIMIT - 1));
endmodule

// File: rtl/gerase_seq.sv
module gerase_seq
   import gerase_pkg::*;
#(
   parameter int         CLK_HZ       = 100000000,
   parameter int         WAIT_US      = 5000,
   parameter int         N_DUMMY      = 8,
   parameter int         POLL_LIMIT   = 4096,
   parameter logic [7:0] ERR_MASK     = 8'h7F,
   parameter logic [7:0] CMD_WR_CTRL  = 8'h6A,
   parameter logic [7:0] OP_ERASE_ALL = 8'h72,
   parameter logic [7:0] CMD_RD_INC   = 8'h6D,
   parameter logic [7:0] CMD_RD_CTRL  = 8'h6B
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic       shf_busy,
   input  logic       rx_valid,
   input  logic [7:0] rx_byte,
   output logic       tx_valid,
   output logic [7:0] tx_byte,
   output logic       done,
   output logic       error,
   output logic [1:0] err_code
);
   localparam int WAIT_CYC = (CLK_HZ / 1000) * WAIT_US / 1000;

   generate
      if (WAIT_CYC < 1)   begin : g_bad_wait  $error("settling wait must be at least one cycle"); end
      if (N_DUMMY < 1)    begin : g_bad_dummy $error("N_DUMMY must be at least 1"); end
      if (ERR_MASK[7])    begin : g_bad_mask  $error("busy bit 7 must not be in ERR_MASK"); end
      if (POLL_LIMIT < 0) begin : g_bad_poll  $error("POLL_LIMIT must not be negative"); end
   endgenerate

   gerase_state_t state;
   logic          can_tx, tmr_zero, dum_last, poll_last;
   logic          rx_err, rx_busy;

   assign can_tx  = !shf_busy && !tx_valid;
   assign rx_err  = |(rx_byte & ERR_MASK);
   assign rx_busy = rx_byte[7];

   gerase_timer #(.CYCLES(WAIT_CYC)) u_wait (
      .clk  (clk),
      .rst_n(rst_n),
      .load (state == ST_OP && can_tx),
      .zero (tmr_zero)
   );

   gerase_ctr #(.LIMIT(N_DUMMY)) u_dummy (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (state == ST_IDLE),
      .inc  (state == ST_DRX && rx_valid),
      .last (dum_last)
   );

   generate
      if (POLL_LIMIT > 0) begin : g_poll_bound
         gerase_ctr #(.LIMIT(POLL_LIMIT)) u_poll (
            .clk  (clk),
            .rst_n(rst_n),
            .clr  (state == ST_WAIT),
            .inc  (state == ST_PRX && rx_valid),
            .last (poll_last)
         );
      end else begin : g_poll_free
         assign poll_last = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         tx_valid <= 1'b0;
         tx_byte  <= '0;
         done     <= 1'b0;
         error    <= 1'b0;
         err_code <= EC_NONE;
      end else begin
         tx_valid <= 1'b0;
         done     <= 1'b0;
         error    <= 1'b0;
         unique case (state)
            ST_IDLE: if (start) state <= ST_CMD;
            ST_CMD: if (can_tx) begin
               tx_valid <= 1'b1;
               tx_byte  <= CMD_WR_CTRL;
               state    <= ST_OP;
            end
            ST_OP: if (can_tx) begin
               tx_valid <= 1'b1;
               tx_byte  <= OP_ERASE_ALL;
               state    <= ST_WAIT;
            end
            ST_WAIT: if (tmr_zero) state <= ST_DRD;
            ST_DRD: if (can_tx) begin
               tx_valid <= 1'b1;
               tx_byte  <= CMD_RD_INC;
               state    <= ST_DRX;
            end
            ST_DRX: if (rx_valid) state <= dum_last ? ST_POLL : ST_DRD;
            ST_POLL: if (can_tx) begin
               tx_valid <= 1'b1;
               tx_byte  <= CMD_RD_CTRL;
               state    <= ST_PRX;
            end
            ST_PRX: if (rx_valid) begin
               if (rx_err) begin
                  error    <= 1'b1;
                  err_code <= EC_STATUS;
                  state    <= ST_IDLE;
               end else if (!rx_busy) begin
                  done     <= 1'b1;
                  err_code <= EC_NONE;
                  state    <= ST_IDLE;
               end else if (poll_last) begin
                  error    <= 1'b1;
                  err_code <= EC_TIMEOUT;
                  state    <= ST_IDLE;
               end else begin
                  state    <= ST_POLL;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/gerase_chk.sv
module gerase_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       shf_busy,
   input logic       tx_valid,
   input logic       done,
   input logic       error,
   input logic [1:0] err_code
);
   p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   p_err_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      error |=> !error);
   p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && error));
   p_tx_free_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_valid) |-> !$past(shf_busy));
   p_tx_gap_r11: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |=> !tx_valid);
   p_err_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
      error |-> (err_code == 2'b01 || err_code == 2'b10));
   p_done_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> err_code == 2'b00);
endmodule

bind gerase_seq gerase_chk u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .shf_busy(shf_busy),
   .tx_valid(tx_valid),
   .done    (done),
   .error   (error),
   .err_code(err_code)
);

// File: tb/sim_gerase_seq.sv
module sim_gerase_seq;
   localparam int         CLK_HZ = 20000;
   localparam int         WAIT_US = 5000;
   localparam int         WCYC = (CLK_HZ / 1000) * WAIT_US / 1000;
   localparam int         PLIM = 6;
   localparam logic [7:0] C_WR = 8'h6A, C_ER = 8'h72, C_RI = 8'h6D, C_RC = 8'h6B;

   // vector: busy polls before final | final status | shifter latency | expected code | done expected
   localparam int NV = 7;
   localparam logic [22:0] VEC [NV] = '{
      {8'd0, 8'h00, 4'd2, 2'b00, 1'b1},
      {8'd3, 8'h00, 4'd5, 2'b00, 1'b1},
      {8'd2, 8'h04, 4'd3, 2'b01, 1'b0},
      {8'd1, 8'h90, 4'd2, 2'b01, 1'b0},
      {8'd5, 8'h00, 4'd2, 2'b00, 1'b1},
      {8'd9, 8'h00, 4'd3, 2'b10, 1'b0},
      {8'd0, 8'h7F, 4'd4, 2'b01, 1'b0}
   };

   logic clk = 0, rst_n = 0, start = 0, shf_busy = 0, rx_valid = 0;
   logic [7:0] rx_byte = 0;
   logic tx_valid, done, error;
   logic [7:0] tx_byte;
   logic [1:0] err_code;

   always #5 clk = ~clk;

   gerase_seq #(.CLK_HZ(CLK_HZ), .WAIT_US(WAIT_US), .POLL_LIMIT(PLIM)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .shf_busy(shf_busy),
      .rx_valid(rx_valid), .rx_byte(rx_byte), .tx_valid(tx_valid),
      .tx_byte(tx_byte), .done(done), .error(error), .err_code(err_code));

   int errs = 0, checks = 0;
   int cyc = 0;
   logic [7:0] cmds [64];
   int ncmd, viol, n_done, n_err, res_cyc, last_rx, op_cyc, rd_cyc, polls, maxw, runw;
   logic [1:0] res_code;
   int v_busy, v_lat, m_cnt;
   logic [7:0] v_fin, m_cmd;
   logic m_busy;

   task automatic chk(input logic ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic clear_log();
      ncmd = 0; viol = 0; n_done = 0; n_err = 0; res_cyc = 0; last_rx = 0;
      op_cyc = 0; rd_cyc = 0; polls = 0; maxw = 0; runw = 0; res_code = 0;
      m_busy = 0; shf_busy = 0; rx_valid = 0;
   endtask

   // shifter model and monitor, all on the falling edge
   always @(negedge clk) begin
      cyc++;
      if (done || error) begin
         runw++;
         if (runw > maxw) maxw = runw;
         if (done) n_done++;
         if (error) n_err++;
         res_cyc = cyc; res_code = err_code;
      end else runw = 0;
      rx_valid = 0;
      if (tx_valid) begin
         if (m_busy) viol++;
         if (ncmd < 64) cmds[ncmd] = tx_byte;
         ncmd++;
         if (tx_byte == C_ER) op_cyc = cyc;
         if (tx_byte == C_RI && rd_cyc == 0) rd_cyc = cyc;
         m_busy = 1; m_cnt = v_lat; m_cmd = tx_byte;
      end else if (m_busy) begin
         if (m_cnt <= 1) begin
            m_busy = 0;
            if (m_cmd == C_RI) begin
               rx_valid = 1; rx_byte = 8'hFF;
            end else if (m_cmd == C_RC) begin
               rx_valid = 1;
               rx_byte = (polls < v_busy) ? 8'h80 : v_fin;
               polls++;
               last_rx = cyc;
            end
         end else m_cnt--;
      end
      shf_busy = m_busy;
   end

   task automatic run(input logic [22:0] v, input logic mid_start, input string nm);
      int guard;
      int n_wr, n_ri, exp_polls, ncmd_end;
      clear_log();
      v_busy = int'(v[22:15]); v_fin = v[14:7]; v_lat = int'(v[6:3]);
      @(negedge clk); start = 1;
      @(negedge clk); start = 0;
      if (mid_start) begin
         repeat (20) @(negedge clk);
         start = 1; @(negedge clk); start = 0;
      end
      guard = 0;
      while (n_done + n_err == 0 && guard < 5000) begin
         @(negedge clk); guard++;
      end
      if (guard >= 5000) chk(0, {nm, " R9 watchdog"}, guard, 5000);
      ncmd_end = ncmd;
      repeat (30) @(negedge clk);
      n_wr = 0; n_ri = 0;
      for (int i = 0; i < ncmd && i < 64; i++) begin
         if (cmds[i] == C_WR) n_wr++;
         if (cmds[i] == C_RI) n_ri++;
      end
      exp_polls = (v_busy + 1 < PLIM) ? v_busy + 1 : PLIM;
      chk(cmds[0] == C_WR && cmds[1] == C_ER, {nm, " R2 first bytes"}, int'({cmds[0], cmds[1]}), int'({C_WR, C_ER}));
      chk(rd_cyc - op_cyc >= WCYC && rd_cyc - op_cyc <= WCYC + 4, {nm, " R3 wait gap"}, rd_cyc - op_cyc, WCYC);
      chk(n_ri == 8 && cmds[9] == C_RI && cmds[10] == C_RC, {nm, " R4 dummy reads"}, n_ri, 8);
      chk(polls == exp_polls, {nm, " R5 R8 poll count"}, polls, exp_polls);
      chk(n_done == int'(v[0]) && n_err == int'(!v[0]), {nm, " R6 R7 outcome"}, n_done, int'(v[0]));
      chk(res_code == v[2:1], {nm, " R7 R8 err_code"}, int'(res_code), int'(v[2:1]));
      chk(res_cyc - last_rx == 1, {nm, " R6 result latency"}, res_cyc - last_rx, 1);
      chk(maxw == 1, {nm, " R9 pulse width"}, maxw, 1);
      chk(viol == 0, {nm, " R11 launch while busy"}, viol, 0);
      chk(ncmd == ncmd_end && n_wr == 1, {nm, " R10 single run"}, n_wr, 1);
   endtask

   initial begin
      clear_log();
      v_busy = 0; v_fin = 0; v_lat = 2;
      repeat (3) @(negedge clk);
      chk(!tx_valid && !done && !error, "R1 reset outputs", int'({tx_valid, done, error}), 0);
      rst_n = 1;
      repeat (3) @(negedge clk);
      chk(!tx_valid && !done && !error && ncmd == 0, "R1 idle after reset", ncmd, 0);
      for (int k = 0; k < NV; k++) run(VEC[k], 1'b0, $sformatf("vec%0d", k));
      // directed: start pulsed during the settling wait (R10)
      run({8'd2, 8'h00, 4'd3, 2'b00, 1'b1}, 1'b1, "mid_start R10");
      // directed: back-to-back sequence after an error returns to idle (R9)
      run({8'd0, 8'h01, 4'd2, 2'b01, 1'b0}, 1'b0, "err_then R9");
      run({8'd0, 8'h00, 4'd2, 2'b00, 1'b1}, 1'b0, "rerun R9");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule